// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretch and Level Detector

This block watches a digitised supply voltage, presented every clock as an unsigned millivolt code, and derives two things from it. The first is a supply reset: it is held while the supply sits under a fixed trip point. It is released only after the supply has climbed past a slightly higher trip point and then stayed clear of the lower one for a programmable number of clock cycles. No external reset circuit is needed to keep the rest of the chip quiet through ramp-up and brown-out.

The second is a low-supply detector. Software picks one of eight trip levels, spaced 100 mV apart. A flag reports whether the supply is under the chosen level, with 100 mV of hysteresis. Transitions of that flag can raise a one-cycle event, independently enabled for the supply-falling and supply-rising direction. A system interrupt controller can take that event and run an emergency shutdown routine.

Both comparators are registered, so every output follows its cause by one clock. The thresholds, hysteresis widths, code width and the stretch length are parameters.

Top module: `supply_supervisor`

## Requirements
- R1: `supply_rst` is 1 in the clock cycle after any edge that samples `vdd_mv` below POR_FALL_MV (default 1960).
- R2: The reset comparator releases only when `vdd_mv` is at least POR_FALL_MV + POR_HYST_MV (default 2000). Supply codes in [1960, 2000) leave the reset state unchanged in both directions.
- R3: Take the first edge that samples `vdd_mv` at or above the release threshold while reset is held. `supply_rst` stays 1 through that edge and the next TEMPO_CYCLES - 1 edges, and drops to 0 after edge TEMPO_CYCLES counted from it.
- R4: If `vdd_mv` is sampled below POR_FALL_MV while the release count runs, the count restarts from zero. A full TEMPO_CYCLES delay then applies again after the next release.
- R5: Level code L on `pvd_lvl` (3 bits) selects a detector trip level of 2200 + 100*L mV, so 0 is 2200 mV and 7 is 2900 mV. With `pvd_en` = 1, `pvd_out` becomes 1 in the cycle after an edge that samples `vdd_mv` strictly below that level. A value equal to the level is not below it.
- R6: Once `pvd_out` is 1, it returns to 0 only after an edge that samples `vdd_mv` at or above the trip level plus 100 mV. This also applies when the level code changes while the flag is set.
- R7: With `pvd_en` = 0, `pvd_out` and `pvd_evt` are 0 in the cycle after the edge. Disabling raises no event, and re-enabling with the supply low re-detects the condition as a new 0-to-1 transition.
- R8: `pvd_evt` is 1 for the cycle right after `pvd_out` changes: a 0-to-1 change (supply fell) only when `pvd_fall_en` = 1, and a 1-to-0 change (supply rose) only when `pvd_rise_en` = 1. Otherwise it is 0.
- R9: While `rst_n` is 0, `supply_rst` is 1, `pvd_out` is 0 and `pvd_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| vdd_mv | input | VW (12) | Supply sample, unsigned millivolts |
| pvd_en | input | 1 | Detector enable |
| pvd_lvl | input | LVL_W (3) | Detector trip level code |
| pvd_rise_en | input | 1 | Event enable for supply rising back above the level |
| pvd_fall_en | input | 1 | Event enable for supply dropping below the level |
| supply_rst | output | 1 | Supply reset, active high |
| pvd_out | output | 1 | 1 while the supply is judged below the detector level |
| pvd_evt | output | 1 | One-cycle detector transition event |

## Verification
The bench sits the supply just under the release point and just on the lower trip point. A comparator without hysteresis, or with the two thresholds swapped, would toggle reset there. It counts the exact edge at which reset drops after release. An off-by-one stretch counter moves that edge by a cycle. It also dips the supply during the count: a counter that pauses instead of restarting would release early. On the detector side, it uses supply codes equal to the trip level, the top and bottom level codes, a level change while the flag is set, and disable/re-enable while the supply is low. These expose a wrong level formula, a missing detector hysteresis, an event raised by disabling, and events that ignore their direction enables.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

   // Kind of transition seen on a registered low-supply flag.
   typedef enum logic [1:0] {
      EDGE_NONE        = 2'd0,
      EDGE_SUPPLY_FALL = 2'd1,
      EDGE_SUPPLY_RISE = 2'd2
   } edge_kind_e;

   // Trip level in millivolts for a given level code.
   function automatic int level_mv(input int base_mv, input int step_mv, input int code);
      return base_mv + step_mv * code;
   endfunction

endpackage

// File: rtl/supsv_hyst_cmp.sv
// Registered comparator with hysteresis: low_q sets when level < thr_lo,
// clears when level >= thr_hi, and is forced clear while en is 0.
module supsv_hyst_cmp #(
   parameter int   VW           = 12,
   parameter logic LOW_AT_RESET = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [VW-1:0] level,
   input  logic [VW-1:0] thr_lo,
   input  logic [VW-1:0] thr_hi,
   output logic          low_q
);

   logic low_d;

   always_comb begin
      low_d = low_q;
      if (!en)
         low_d = 1'b0;
      else if (low_q && (level >= thr_hi))
         low_d = 1'b0;
      else if (!low_q && (level < thr_lo))
         low_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_q <= LOW_AT_RESET;
      else
         low_q <= low_d;
   end

   // R2 / R6: inside the band the state is held.
   a_r2_hold_low : assert property (@(posedge clk) disable iff (!rst_n)
      (en && low_q && (level < thr_hi)) |=> low_q);
   a_r6_hold_high : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !low_q && (level >= thr_lo)) |=> !low_q);

endmodule

// File: rtl/supsv_rst_stretch.sv
// Holds reset while the supply is low and for TEMPO cycles after it clears.
module supsv_rst_stretch #(
   parameter int TEMPO = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic below,
   output logic rst_o
);

   generate
      if (TEMPO == 0) begin : g_direct
         assign rst_o = below;
      end else begin : g_count
         localparam int CW = $clog2(TEMPO + 1);
         localparam logic [CW-1:0] DONE = CW'(TEMPO);

         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (below)
               cnt <= '0;
            else if (cnt != DONE)
               cnt <= cnt + 1'b1;
         end

         assign rst_o = below | (cnt != DONE);

         // R4: a low supply restarts the count.
         a_r4_restart : assert property (@(posedge clk) disable iff (!rst_n)
            below |=> (cnt == '0));
      end
   endgenerate

endmodule

// File: rtl/supsv_edge_evt.sv
// One-cycle event on direction-enabled transitions of the low-supply flag.
module supsv_edge_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic flag,
   input  logic rise_en,
   input  logic fall_en,
   output logic evt
);
   import supsv_pkg::*;

   logic       prev_q;
   edge_kind_e kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= 1'b0;
      else
         prev_q <= en ? flag : 1'b0;
   end

   always_comb begin
      kind = EDGE_NONE;
      if (flag && !prev_q)
         kind = EDGE_SUPPLY_FALL;
      else if (!flag && prev_q)
         kind = EDGE_SUPPLY_RISE;
   end

   always_comb begin
      unique case (kind)
         EDGE_SUPPLY_FALL: evt = fall_en;
         EDGE_SUPPLY_RISE: evt = rise_en;
         default:          evt = 1'b0;
      endcase
   end

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
   parameter int VW           = 12,
   parameter int POR_FALL_MV  = 1960,
   parameter int POR_HYST_MV  = 40,
   parameter int TEMPO_CYCLES = 64,
   parameter int LVL_W        = 3,
   parameter int PVD_BASE_MV  = 2200,
   parameter int PVD_STEP_MV  = 100,
   parameter int PVD_HYST_MV  = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VW-1:0]    vdd_mv,
   input  logic             pvd_en,
   input  logic [LVL_W-1:0] pvd_lvl,
   input  logic             pvd_rise_en,
   input  logic             pvd_fall_en,
   output logic             supply_rst,
   output logic             pvd_out,
   output logic             pvd_evt
);
   import supsv_pkg::*;

   localparam int NLVL        = 1 << LVL_W;
   localparam int VMAX        = (1 << VW) - 1;
   localparam int POR_RISE_MV = POR_FALL_MV + POR_HYST_MV;
   localparam int PVD_TOP_MV  = level_mv(PVD_BASE_MV, PVD_STEP_MV, NLVL - 1) + PVD_HYST_MV;

   // Elaboration-time parameter checks.
   generate
      if (POR_HYST_MV <= 0 || PVD_HYST_MV <= 0) begin : g_bad_hyst
         $error("supply_supervisor: hysteresis widths must be positive");
      end
      if (POR_RISE_MV > VMAX || PVD_TOP_MV > VMAX) begin : g_bad_range
         $error("supply_supervisor: thresholds do not fit the supply code width");
      end
      if (TEMPO_CYCLES < 0 || LVL_W < 1) begin : g_bad_cfg
         $error("supply_supervisor: bad stretch length or level width");
      end
   endgenerate

   // Detector trip level table, one entry per level code.
   logic [VW-1:0] lvl_thr [NLVL];
   generate
      for (genvar g = 0; g < NLVL; g++) begin : g_lvl
         assign lvl_thr[g] = VW'(level_mv(PVD_BASE_MV, PVD_STEP_MV, g));
      end
   endgenerate

   logic [VW-1:0] pvd_thr_lo;
   logic [VW-1:0] pvd_thr_hi;
   logic          por_low;
   logic          pvd_low;

   assign pvd_thr_lo = lvl_thr[pvd_lvl];
   assign pvd_thr_hi = pvd_thr_lo + VW'(PVD_HYST_MV);

   supsv_hyst_cmp #(.VW(VW), .LOW_AT_RESET(1'b1)) u_por_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (1'b1),
      .level  (vdd_mv),
      .thr_lo (VW'(POR_FALL_MV)),
      .thr_hi (VW'(POR_RISE_MV)),
      .low_q  (por_low)
   );

   supsv_rst_stretch #(.TEMPO(TEMPO_CYCLES)) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .below (por_low),
      .rst_o (supply_rst)
   );

   supsv_hyst_cmp #(.VW(VW), .LOW_AT_RESET(1'b0)) u_pvd_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (pvd_en),
      .level  (vdd_mv),
      .thr_lo (pvd_thr_lo),
      .thr_hi (pvd_thr_hi),
      .low_q  (pvd_low)
   );

   supsv_edge_evt u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (pvd_en),
      .flag    (pvd_low),
      .rise_en (pvd_rise_en),
      .fall_en (pvd_fall_en),
      .evt     (pvd_evt)
   );

   assign pvd_out = pvd_low;

   a_r1_low_forces_reset : assert property (@(posedge clk) disable iff (!rst_n)
      (vdd_mv < VW'(POR_FALL_MV)) |=> supply_rst);

   a_r3_release_needs_supply : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(supply_rst) |-> ($past(vdd_mv) >= VW'(POR_FALL_MV)));

   a_r5_below_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      (pvd_en && (vdd_mv < pvd_thr_lo)) |=> pvd_out);

   a_r7_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !pvd_en |=> (!pvd_out && !pvd_evt));

   a_r8_fall_evt_gated : assert property (@(posedge clk) disable iff (!rst_n)
      (pvd_evt && pvd_out) |-> pvd_fall_en);

   a_r8_rise_evt_gated : assert property (@(posedge clk) disable iff (!rst_n)
      (pvd_evt && !pvd_out) |-> pvd_rise_en);

endmodule

// File: tb/test_supply_supervisor.sv
module test_supply_supervisor;

   localparam int TEMPO = 8;

   typedef struct packed {
      logic [11:0] vdd;
      logic        en;
      logic [2:0]  lvl;
      logic        re;
      logic        fe;
      logic        out;
      logic        evt;
   } vec_t;

   // One row per clock: inputs, then expected pvd_out / pvd_evt after the edge.
   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{12'd3300, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
      '{12'd2250, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
      '{12'd2199, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1},
      '{12'd2199, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0},
      '{12'd2250, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0},
      '{12'd2299, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0},
      '{12'd2300, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1},
      '{12'd2300, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
      '{12'd2150, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{12'd2350, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{12'd2899, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1},
      '{12'd2999, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0},
      '{12'd3000, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1},
      '{12'd2500, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0},
      '{12'd2499, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1},
      '{12'd2499, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1},
      '{12'd2600, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1, 1'b1},
      '{12'd2600, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0},
      '{12'd2600, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0},
      '{12'd2600, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] vdd_mv = '0;
   logic        pvd_en = 1'b0;
   logic [2:0]  pvd_lvl = '0;
   logic        pvd_rise_en = 1'b0;
   logic        pvd_fall_en = 1'b0;
   logic        supply_rst;
   logic        pvd_out;
   logic        pvd_evt;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   supply_supervisor #(.TEMPO_CYCLES(TEMPO)) i_supply_supervisor (
      .clk         (clk),
      .rst_n       (rst_n),
      .vdd_mv      (vdd_mv),
      .pvd_en      (pvd_en),
      .pvd_lvl     (pvd_lvl),
      .pvd_rise_en (pvd_rise_en),
      .pvd_fall_en (pvd_fall_en),
      .supply_rst  (supply_rst),
      .pvd_out     (pvd_out),
      .pvd_evt     (pvd_evt)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      bit seen_hi;
      repeat (3) @(negedge clk);
      // R9: state while the logic reset is held
      check("R9 supply_rst", int'(supply_rst), 1);
      check("R9 pvd_out", int'(pvd_out), 0);
      check("R9 pvd_evt", int'(pvd_evt), 0);
      rst_n = 1'b1;

      // R1: low supply keeps reset
      vdd_mv = 12'd1500;
      repeat (3) step();
      check("R1 low supply", int'(supply_rst), 1);

      // R2: just under the release threshold
      vdd_mv = 12'd1999;
      repeat (4) step();
      check("R2 below release", int'(supply_rst), 1);

      // R3: release after exactly TEMPO extra edges
      vdd_mv = 12'd2000;
      seen_hi = 1'b1;
      for (int i = 0; i < TEMPO; i++) begin
         step();
         if (!supply_rst) seen_hi = 1'b0;
      end
      check("R3 held during stretch", int'(seen_hi), 1);
      step();
      check("R3 released", int'(supply_rst), 0);

      // R2: sitting on the falling threshold does not re-assert
      vdd_mv = 12'd1960;
      repeat (3) step();
      check("R2 on falling threshold", int'(supply_rst), 0);

      // R1: one code lower asserts in one cycle
      vdd_mv = 12'd1959;
      step();
      check("R1 brown-out", int'(supply_rst), 1);

      // R4: dip during count restarts it
      vdd_mv = 12'd2100;
      repeat (4) step();
      check("R4 counting", int'(supply_rst), 1);
      vdd_mv = 12'd1900;
      step();
      check("R4 dip", int'(supply_rst), 1);
      vdd_mv = 12'd2100;
      seen_hi = 1'b1;
      for (int i = 0; i < TEMPO; i++) begin
         step();
         if (!supply_rst) seen_hi = 1'b0;
      end
      check("R4 full delay after restart", int'(seen_hi), 1);
      step();
      check("R4 released", int'(supply_rst), 0);

      // R5 R6 R7 R8: detector table
      for (int k = 0; k < NV; k++) begin
         vdd_mv      = VECS[k].vdd;
         pvd_en      = VECS[k].en;
         pvd_lvl     = VECS[k].lvl;
         pvd_rise_en = VECS[k].re;
         pvd_fall_en = VECS[k].fe;
         step();
         check($sformatf("R5/R6/R7 row %0d pvd_out", k), int'(pvd_out), int'(VECS[k].out));
         check($sformatf("R8 row %0d pvd_evt", k), int'(pvd_evt), int'(VECS[k].evt));
      end
      check("R1 reset stays released in table", int'(supply_rst), 0);

      done = 1'b1;
      finish_run();
   end

endmodule